// File: doc/BRIEF.md
# Masked Compare-and-Swap Cycle Unit

This unit sits between a local requester and a remote bus master port. It turns an ordinary local read of one configured word into an atomic read-modify-write on the remote side. Software sets a cycle mode, a target word address, a bit mask, a compare word and a swap word through a small write-only register port. A local read that hits the target in the configured space becomes a locked remote read. If the masked bits of the returned data equal the masked compare word, a locked remote write follows. That write carries the swap bits inside the mask and the bits read back outside it. The requester always receives the original read data.

A second mode does no data manipulation. In that mode the unit holds the remote lock for the whole of one matching read or write. Every other local access goes to the remote port unchanged and without the lock. Both sides use a request/acknowledge handshake. The requester holds `loc_req_i` until it sees a one-cycle `loc_ack_o`. The unit holds `rem_req_o` and its qualifiers steady until it receives a one-cycle `rem_ack_i`.

Top module: `cas_cycle_unit`

## Requirements
- R1: After reset the unit drives no remote request, no lock and no local acknowledge. All configuration registers are zero, so every access passes straight through.
- R2: Configuration select codes are 0 mode, 1 target address, 2 mask, 3 compare and 4 swap. Mode bits [1:0] give the cycle kind: 0 off, 1 read-modify-write, 2 locked hold, 3 off. Mode bit 2 selects the space: 1 is I/O, 0 is memory.
- R3: An access that is not special makes exactly one remote access. That access has the local direction, space, address and write data, and the lock stays low. The remote read data and error are returned to the requester.
- R4: The target address register forces bits [1:0] to zero. Matching compares only address bits [31:2], together with the space bit.
- R5: In read-modify-write mode a matching local read does a locked remote read. If ((read ^ compare) & mask) is zero, a locked remote write to the same address follows, with data (read & ~mask) | (swap & mask).
- R6: If the masked compare fails, no write is issued.
- R7: For a read, the local read data is the unmodified remote read data, whether or not the compare succeeds.
- R8: In locked hold mode a matching read or write makes one remote access with the lock asserted and no write-back.
- R9: In read-modify-write mode a local write to the target address passes through unlocked.
- R10: For a locked sequence the lock rises once and stays high from the first remote request until the final remote acknowledge. It is low in the cycle after that acknowledge.
- R11: A remote error on either access ends the sequence at once, with no further remote access. The requester then gets an acknowledge with `loc_err_o` high, and the lock is released.
- R12: A configuration write in the same cycle that a local request is accepted does not affect that request; the request is decoded with the previous configuration.
- R13: `loc_ack_o` is a single-cycle pulse in the cycle after the final remote acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| loc_req_i | input | 1 | Local request, held until acknowledge |
| loc_we_i | input | 1 | Local write (1) or read (0) |
| loc_io_i | input | 1 | Local space: 1 I/O, 0 memory |
| loc_addr_i | input | 32 | Local byte address |
| loc_wdata_i | input | 32 | Local write data |
| loc_ack_o | output | 1 | Local acknowledge pulse |
| loc_rdata_o | output | 32 | Local read data, valid with acknowledge |
| loc_err_o | output | 1 | Local error, valid with acknowledge |
| rem_req_o | output | 1 | Remote request |
| rem_we_o | output | 1 | Remote write (1) or read (0) |
| rem_io_o | output | 1 | Remote space |
| rem_lock_o | output | 1 | Remote bus lock |
| rem_addr_o | output | 32 | Remote address |
| rem_wdata_o | output | 32 | Remote write data |
| rem_ack_i | input | 1 | Remote acknowledge pulse |
| rem_err_i | input | 1 | Remote error, valid with acknowledge |
| rem_rdata_i | input | 32 | Remote read data, valid with acknowledge |

## Verification
A configuration write and the acceptance of a local request can land on the same clock edge. The bench provokes this by clearing the mode register on the exact edge where a matching read is taken up. It judges the result by seeing a complete locked read-modify-write, with two remote accesses and one lock rise, for that read. The next identical read must then pass through unlocked with a single access.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int unsigned MODE_W      = 3;
  localparam int unsigned MODE_IO_BIT = 2;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_TGT  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_CMP  = 3'd3,
    SEL_SWAP = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    KIND_OFF  = 2'd0,
    KIND_RMW  = 2'd1,
    KIND_HOLD = 2'd2,
    KIND_RSVD = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WB,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/cas_cfg_regs.sv
module cas_cfg_regs
  import cas_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned LSB = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          sel_i,
  input  logic [DW-1:0]       wdata_i,
  output cyc_kind_e           kind_o,
  output logic                io_o,
  output logic [AW-LSB-1:0]   tgt_word_o,
  output logic [DW-1:0]       mask_o,
  output logic [DW-1:0]       cmp_o,
  output logic [DW-1:0]       swp_o
);
  logic [MODE_W-1:0] mode_q;
  logic [AW-LSB-1:0] tgt_q;
  logic [DW-1:0]     mask_q, cmp_q, swp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tgt_q  <= '0;
      mask_q <= '0;
      cmp_q  <= '0;
      swp_q  <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_MODE: mode_q <= wdata_i[MODE_W-1:0];
        SEL_TGT:  tgt_q  <= wdata_i[AW-1:LSB];  // word aligned by storage
        SEL_MASK: mask_q <= wdata_i;
        SEL_CMP:  cmp_q  <= wdata_i;
        SEL_SWAP: swp_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign kind_o     = cyc_kind_e'(mode_q[1:0]);
  assign io_o       = mode_q[MODE_IO_BIT];
  assign tgt_word_o = tgt_q;
  assign mask_o     = mask_q;
  assign cmp_o      = cmp_q;
  assign swp_o      = swp_q;
endmodule

// File: rtl/cas_match.sv
module cas_match
  import cas_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned LSB = 2
) (
  input  cyc_kind_e         kind_i,
  input  logic              io_i,
  input  logic [AW-LSB-1:0] tgt_word_i,
  input  logic              loc_we_i,
  input  logic              loc_io_i,
  input  logic [AW-LSB-1:0] loc_word_i,
  output logic              rmw_o,
  output logic              lock_o
);
  logic hit;

  always_comb begin
    hit    = (loc_word_i == tgt_word_i) && (loc_io_i == io_i);
    rmw_o  = hit && (kind_i == KIND_RMW) && !loc_we_i;
    lock_o = rmw_o || (hit && (kind_i == KIND_HOLD));
  end
endmodule

// File: rtl/cas_merge.sv
module cas_merge #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] cmp_i,
  input  logic [DW-1:0] swp_i,
  output logic          hit_o,
  output logic [DW-1:0] wb_o
);
  always_comb begin
    hit_o = ~|((rd_i ^ cmp_i) & mask_i);
    wb_o  = (rd_i & ~mask_i) | (swp_i & mask_i);
  end
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loc_req_i,
  input  logic          loc_we_i,
  input  logic          loc_io_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  input  logic          rmw_i,
  input  logic          lock_i,
  input  logic          hit_i,
  input  logic [DW-1:0] wb_data_i,
  output logic          loc_ack_o,
  output logic [DW-1:0] loc_rdata_o,
  output logic          loc_err_o,
  output logic          rem_req_o,
  output logic          rem_we_o,
  output logic          rem_io_o,
  output logic          rem_lock_o,
  output logic [AW-1:0] rem_addr_o,
  output logic [DW-1:0] rem_wdata_o,
  input  logic          rem_ack_i,
  input  logic          rem_err_i,
  input  logic [DW-1:0] rem_rdata_i
);
  seq_state_e    state_q;
  logic          we_q, io_q, rmw_q, lock_q, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      rmw_q   <= 1'b0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (loc_req_i) begin
          state_q <= ST_RD;
          we_q    <= loc_we_i;
          io_q    <= loc_io_i;
          addr_q  <= loc_addr_i;
          wdata_q <= loc_wdata_i;
          rmw_q   <= rmw_i;
          lock_q  <= lock_i;
          err_q   <= 1'b0;
        end
        ST_RD: if (rem_ack_i) begin
          rdata_q <= rem_rdata_i;
          if (rem_err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else if (rmw_q && hit_i) begin
            we_q    <= 1'b1;
            wdata_q <= wb_data_i;  // merge captured at read completion
            state_q <= ST_WB;
          end else begin
            state_q <= ST_RESP;
          end
        end
        ST_WB: if (rem_ack_i) begin
          err_q   <= rem_err_i;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_req_o   = (state_q == ST_RD) || (state_q == ST_WB);
  assign rem_we_o    = we_q;
  assign rem_io_o    = io_q;
  assign rem_addr_o  = addr_q;
  assign rem_wdata_o = wdata_q;
  assign rem_lock_o  = lock_q && rem_req_o;
  assign loc_ack_o   = (state_q == ST_RESP);
  assign loc_rdata_o = rdata_q;
  assign loc_err_o   = err_q && loc_ack_o;
endmodule

// File: rtl/cas_cycle_unit.sv
module cas_cycle_unit
  import cas_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          loc_req_i,
  input  logic          loc_we_i,
  input  logic          loc_io_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic          loc_ack_o,
  output logic [DW-1:0] loc_rdata_o,
  output logic          loc_err_o,
  output logic          rem_req_o,
  output logic          rem_we_o,
  output logic          rem_io_o,
  output logic          rem_lock_o,
  output logic [AW-1:0] rem_addr_o,
  output logic [DW-1:0] rem_wdata_o,
  input  logic          rem_ack_i,
  input  logic          rem_err_i,
  input  logic [DW-1:0] rem_rdata_i
);
  localparam int unsigned LSB = $clog2(DW / 8);

  cyc_kind_e         kind;
  logic              sp_io, rmw, lock, hit;
  logic [AW-LSB-1:0] tgt_word;
  logic [DW-1:0]     mask, cmp, swp, wb_data;

  cas_cfg_regs #(.AW(AW), .DW(DW), .LSB(LSB)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .kind_o     (kind),
    .io_o       (sp_io),
    .tgt_word_o (tgt_word),
    .mask_o     (mask),
    .cmp_o      (cmp),
    .swp_o      (swp)
  );

  cas_match #(.AW(AW), .LSB(LSB)) u_match (
    .kind_i     (kind),
    .io_i       (sp_io),
    .tgt_word_i (tgt_word),
    .loc_we_i   (loc_we_i),
    .loc_io_i   (loc_io_i),
    .loc_word_i (loc_addr_i[AW-1:LSB]),
    .rmw_o      (rmw),
    .lock_o     (lock)
  );

  cas_merge #(.DW(DW)) u_merge (
    .rd_i   (rem_rdata_i),
    .mask_i (mask),
    .cmp_i  (cmp),
    .swp_i  (swp),
    .hit_o  (hit),
    .wb_o   (wb_data)
  );

  cas_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loc_req_i   (loc_req_i),
    .loc_we_i    (loc_we_i),
    .loc_io_i    (loc_io_i),
    .loc_addr_i  (loc_addr_i),
    .loc_wdata_i (loc_wdata_i),
    .rmw_i       (rmw),
    .lock_i      (lock),
    .hit_i       (hit),
    .wb_data_i   (wb_data),
    .loc_ack_o   (loc_ack_o),
    .loc_rdata_o (loc_rdata_o),
    .loc_err_o   (loc_err_o),
    .rem_req_o   (rem_req_o),
    .rem_we_o    (rem_we_o),
    .rem_io_o    (rem_io_o),
    .rem_lock_o  (rem_lock_o),
    .rem_addr_o  (rem_addr_o),
    .rem_wdata_o (rem_wdata_o),
    .rem_ack_i   (rem_ack_i),
    .rem_err_i   (rem_err_i),
    .rem_rdata_i (rem_rdata_i)
  );
endmodule

// File: rtl/cas_cycle_unit_chk.sv
module cas_cycle_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          loc_ack_o,
  input logic          loc_err_o,
  input logic          rem_req_o,
  input logic          rem_we_o,
  input logic          rem_lock_o,
  input logic [AW-1:0] rem_addr_o,
  input logic          rem_ack_i,
  input logic          rem_err_i
);
  // R13
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_ack_o |=> !loc_ack_o);

  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_lock_o && !rem_ack_i) |=> rem_lock_o);

  // R10
  lock_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_lock_o |-> rem_req_o);

  // R11
  err_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_req_o && rem_ack_i && rem_err_i) |=> (!rem_req_o && loc_ack_o && loc_err_o && !rem_lock_o));

  // R3
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_req_o && !rem_ack_i) |=> (rem_req_o && $stable(rem_addr_o) && $stable(rem_we_o)));
endmodule

bind cas_cycle_unit cas_cycle_unit_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .loc_ack_o  (loc_ack_o),
  .loc_err_o  (loc_err_o),
  .rem_req_o  (rem_req_o),
  .rem_we_o   (rem_we_o),
  .rem_lock_o (rem_lock_o),
  .rem_addr_o (rem_addr_o),
  .rem_ack_i  (rem_ack_i),
  .rem_err_i  (rem_err_i)
);

// File: tb/cas_cycle_unit_tb.sv
module cas_cycle_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] D = 32'h1234_5678;

  typedef struct packed {
    logic [2:0]  mode;
    logic [31:0] tgt;
    logic [31:0] mask;
    logic [31:0] cmp;
    logic [31:0] swp;
    logic        we;
    logic        io;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic [1:0]  err_at;
    logic [2:0]  n_acc;
    logic        lock;
    logic [31:0] exp_wr;
    logic        exp_err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h1000, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b0, 32'h0,        1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd2, 1'b1, 32'h123456AB, 1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h77,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b1, 32'h0,        1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1004, 32'h0,        D, 2'd0, 3'd1, 1'b0, 32'h0,        1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b1, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b0, 32'h0,        1'b0},
    '{3'd5, 32'h1000, 32'hFFFF0000, 32'h12340000, 32'hCAFE0000, 1'b0, 1'b1, 32'h1000, 32'h0,        D, 2'd0, 3'd2, 1'b1, 32'hCAFE5678, 1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b1, 1'b0, 32'h1000, 32'h55,       D, 2'd0, 3'd1, 1'b0, 32'h55,       1'b0},
    '{3'd2, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b1, 32'h0,        1'b0},
    '{3'd2, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b1, 1'b0, 32'h1000, 32'hDEADBEEF, D, 2'd0, 3'd1, 1'b1, 32'hDEADBEEF, 1'b0},
    '{3'd1, 32'h1003, 32'hFFFFFFFF, D,            32'h0,        1'b0, 1'b0, 32'h1002, 32'h0,        D, 2'd0, 3'd2, 1'b1, 32'h0,        1'b0},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd1, 3'd1, 1'b1, 32'h0,        1'b1},
    '{3'd1, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd2, 3'd2, 1'b1, 32'h123456AB, 1'b1},
    '{3'd1, 32'h1000, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd2, 1'b1, D,            1'b0},
    '{3'd3, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b0, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b0, 32'h0,        1'b0},
    '{3'd6, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b1, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b1, 32'h0,        1'b0},
    '{3'd4, 32'h1000, 32'hFF,       32'h78,       32'hAB,       1'b0, 1'b1, 32'h1000, 32'h0,        D, 2'd0, 3'd1, 1'b0, 32'h0,        1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        loc_req_i = 1'b0, loc_we_i = 1'b0, loc_io_i = 1'b0;
  logic [31:0] loc_addr_i = '0, loc_wdata_i = '0;
  logic        loc_ack_o, loc_err_o;
  logic [31:0] loc_rdata_o;
  logic        rem_req_o, rem_we_o, rem_io_o, rem_lock_o;
  logic [31:0] rem_addr_o, rem_wdata_o;
  logic        rem_ack_i = 1'b0, rem_err_i = 1'b0;
  logic [31:0] rem_rdata_i = '0;

  int n_tests = 0;
  int n_fail  = 0;

  // remote slave model state
  logic [31:0] sl_rd = '0;
  int          sl_err_at = 0;
  int          n_acc = 0;
  logic        acc_we   [4];
  logic        acc_io   [4];
  logic        acc_lock [4];
  logic [31:0] acc_addr [4];
  logic [31:0] acc_wdata[4];
  int          lock_rises = 0;
  logic        lock_prev = 1'b0;

  // op results
  logic [31:0] res_rdata;
  logic        res_err, res_lock_at_ack, res_ack_after;

  cas_cycle_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (rem_ack_i) begin
      rem_ack_i = 1'b0;
      rem_err_i = 1'b0;
    end else if (rem_req_o) begin
      if (n_acc < 4) begin
        acc_we[n_acc]    = rem_we_o;
        acc_io[n_acc]    = rem_io_o;
        acc_lock[n_acc]  = rem_lock_o;
        acc_addr[n_acc]  = rem_addr_o;
        acc_wdata[n_acc] = rem_wdata_o;
      end
      n_acc       = n_acc + 1;
      rem_ack_i   = 1'b1;
      rem_rdata_i = sl_rd;
      rem_err_i   = (n_acc == sl_err_at);
    end
    if (rem_lock_o && !lock_prev) lock_rises = lock_rises + 1;
    lock_prev = rem_lock_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_ack();
    int guard = 0;
    do begin
      @(negedge clk_i);
      guard++;
    end while (!loc_ack_o && guard < 100);
    res_rdata       = loc_rdata_o;
    res_err         = loc_err_o;
    res_lock_at_ack = rem_lock_o;
    loc_req_i = 1'b0;
    @(negedge clk_i);
    res_ack_after = loc_ack_o;
  endtask

  task automatic start_op(input logic we, input logic io, input logic [31:0] addr, input logic [31:0] wd);
    n_acc = 0; lock_rises = 0;
    loc_req_i = 1'b1; loc_we_i = we; loc_io_i = io; loc_addr_i = addr; loc_wdata_i = wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 rem_req", {31'b0, rem_req_o}, 32'd0);
    chk("R1 lock",    {31'b0, rem_lock_o}, 32'd0);
    chk("R1 ack",     {31'b0, loc_ack_o}, 32'd0);
    rst_ni = 1'b1;
    sl_rd = D; sl_err_at = 0;
    @(negedge clk_i);
    start_op(1'b0, 1'b0, 32'h0, 32'h0);
    wait_ack();
    chk("R1 pass access count", n_acc, 1);
    chk("R1 pass lock", lock_rises, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t v = VEC[i];
      if (v.exp_err) tag = "R11";
      else if (v.mode[1:0] == 2'd2 && v.lock) tag = "R8";
      else if (v.mode[1:0] == 2'd1 && v.we) tag = "R9";
      else if (i == 9) tag = "R4";
      else if (i == 2) tag = "R6";
      else if (v.n_acc == 3'd2) tag = "R5";
      else if (i == 13 || i == 15 || i == 4) tag = "R2";
      else tag = "R3";
      cfg_write(3'd0, {29'b0, v.mode});
      cfg_write(3'd1, v.tgt);
      cfg_write(3'd2, v.mask);
      cfg_write(3'd3, v.cmp);
      cfg_write(3'd4, v.swp);
      sl_rd = v.rd; sl_err_at = int'(v.err_at);
      @(negedge clk_i);
      start_op(v.we, v.io, v.addr, v.wdata);
      wait_ack();
      chk({tag, " access count"}, n_acc, {29'b0, v.n_acc});
      chk({"R10 ", tag, " lock rises"}, lock_rises, {31'b0, v.lock});
      chk({"R10 ", tag, " lock low at ack"}, {31'b0, res_lock_at_ack}, 32'd0);
      chk({"R13 ", tag, " ack one cycle"}, {31'b0, res_ack_after}, 32'd0);
      chk({tag, " err"}, {31'b0, res_err}, {31'b0, v.exp_err});
      for (int k = 0; k < int'(v.n_acc) && k < 4; k++) begin
        chk({tag, " addr"}, acc_addr[k], v.addr);
        chk({tag, " space"}, {31'b0, acc_io[k]}, {31'b0, v.io});
        chk({"R10 ", tag, " lock per access"}, {31'b0, acc_lock[k]}, {31'b0, v.lock});
      end
      if (v.n_acc != 3'd0)
        chk({tag, " first dir"}, {31'b0, acc_we[0]}, {31'b0, v.we});
      if (v.n_acc == 3'd2) begin
        chk({"R5 ", tag, " wb dir"}, {31'b0, acc_we[1]}, 32'd1);
        chk({"R5 ", tag, " wb data"}, acc_wdata[1], v.exp_wr);
      end else if (v.we) begin
        chk({tag, " write data"}, acc_wdata[0], v.exp_wr);
      end
      if (!v.we && !v.exp_err)
        chk({"R7 ", tag, " rdata"}, res_rdata, v.rd);
    end

    // R12 config write on the edge a request is accepted
    cfg_write(3'd0, 32'd1);
    cfg_write(3'd1, 32'h2000);
    cfg_write(3'd2, 32'hFF);
    cfg_write(3'd3, 32'h78);
    cfg_write(3'd4, 32'hAB);
    sl_rd = D; sl_err_at = 0;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd0; cfg_wdata_i = 32'd0;
    start_op(1'b0, 1'b0, 32'h2000, 32'h0);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    wait_ack();
    chk("R12 old mode used count", n_acc, 2);
    chk("R12 old mode used lock", lock_rises, 1);
    chk("R12 old mode wb data", acc_wdata[1], 32'h123456AB);
    @(negedge clk_i);
    start_op(1'b0, 1'b0, 32'h2000, 32'h0);
    wait_ack();
    chk("R12 new mode count", n_acc, 1);
    chk("R12 new mode lock", lock_rises, 0);
    chk("R12 new mode rdata", res_rdata, D);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule